// File: doc/BRIEF.md
# Fixed-Point 4x4 Forward Transform Engine

This block turns a 4x4 tile of signed 16-bit prediction residuals into sixteen signed 16-bit transform coefficients. It uses a scaled integer butterfly in two passes. A horizontal pass runs on every incoming row and stores its results in a small tile buffer. A vertical pass then reads the tile down each column. Each pass has its own rounding offsets. The multiply paths use the fixed weights 2217 and 5352.

Rows arrive one per beat under a valid/ready handshake. Coefficients leave one row per beat under a second valid/ready handshake. Output row 0 carries the DC term and the horizontal frequencies, and output row 3 carries the highest vertical frequency. The tile buffer has two banks, so a new tile can be written while the previous one is read out. With both sides streaming, the engine accepts one tile every four beats.

Top module: `fdct_engine`

## Requirements
- R1: While rst_ni is low and right after it is released, out_valid_o is 0 and in_ready_o is 1. Rows of a partly received tile are discarded by reset, and the next full tile produces correct coefficients.
- R2: The horizontal pass forms a=(x0+x3)*8 and b=(x1+x2)*8 from each input row. Its outputs 0 and 2 are a+b and a-b, each saturated to the range -32768..32767.
- R3: The horizontal pass also forms c=(x1-x2)*8 and d=(x0-x3)*8. Output 1 is (c*2217 + d*5352 + 14500) shifted right arithmetically by 12. Output 3 is (d*2217 - c*5352 + 7500) shifted right arithmetically by 12. Both are saturated to 16 bits, and the intermediates are held at 48-bit precision.
- R4: The vertical pass takes r0..r3 down one column of the horizontal result and forms a=r0+r3 and b=r1+r2. Its outputs 0 and 2 are (a+b+7)>>4 and (a-b+7)>>4, using arithmetic shifts.
- R5: The vertical pass forms c=r1-r2 and d=r0-r3. Its output 1 is ((c*2217 + d*5352 + 12000)>>16) + 1 when d is nonzero, and the same value without the +1 when d is zero.
- R6: Vertical output 3 is (d*2217 - c*5352 + 51000)>>16, saturated to 16 bits.
- R7: Input sample n of a row sits at in_row_i[16n+15:16n]. The output rows leave in order of vertical frequency 0 to 3. Within an output row, lane j at out_row_o[16j+15:16j] holds horizontal frequency j. An all-zero tile gives row 0 = {0,1,0,0} and zeros in every other row.
- R8: An input stall may occur at any beat without corrupting a partial tile. While out_valid_o is 1 and out_ready_i is 0, out_valid_o stays 1 and out_row_o holds its value.
- R9: Two tile banks work in ping-pong. in_ready_o drops only when both banks hold unread tiles. With out_ready_i held at 1, back-to-back tiles are accepted with no stall, one row per cycle.
- R10: out_valid_o is 1 in the cycle after the fourth row of a tile is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input row valid |
| in_ready_o | output | 1 | Engine can take an input row |
| in_row_i | input | 64 | Four residual samples of one row, sample n at bits 16n+15:16n |
| out_valid_o | output | 1 | Output coefficient row valid |
| out_ready_i | input | 1 | Consumer takes the output row |
| out_row_o | output | 64 | Four coefficients of one frequency row, lane j at bits 16j+15:16j |

## Verification
The bench drives residual values at full scale, where the horizontal sums overflow 16 bits. A design with no saturation, or with a narrow product width, wraps these values to the wrong sign. It uses tiles whose column differences d are zero in some columns and nonzero in others. This exposes a +1 correction that is missing or always applied. The all-zero tile exposes rounding offsets that are swapped or changed, because the offsets alone leave a 1 in lane 1 of row 0. Stalls are applied on both sides, and a reset arrives in the middle of a tile. A design that loses track of the row or bank pointers then emits rows in the wrong order, drops or repeats a tile, or blocks a tile it could have taken.

// File: rtl/fdct_pkg.sv
package fdct_pkg;
  localparam int unsigned DW    = 16;
  localparam int unsigned NL    = 4;
  localparam int unsigned ACC_W = 48;
  localparam int unsigned RW    = $clog2(NL);

  typedef logic signed [ACC_W-1:0] acc_t;

  localparam acc_t W_LO     = acc_t'(2217);
  localparam acc_t W_HI     = acc_t'(5352);
  localparam acc_t H_RND1   = acc_t'(14500);
  localparam acc_t H_RND3   = acc_t'(7500);
  localparam acc_t V_RND0   = acc_t'(7);
  localparam acc_t V_RND1   = acc_t'(12000);
  localparam acc_t V_RND3   = acc_t'(51000);
  localparam acc_t ACC_ONE  = acc_t'(1);
  localparam int unsigned H_SH  = 12;
  localparam int unsigned V_SH  = 16;
  localparam int unsigned V_SH0 = 4;
  localparam int unsigned PRE_SH = 3;

  localparam acc_t S_MAX = (acc_t'(1) <<< (DW-1)) - acc_t'(1);
  localparam acc_t S_MIN = -(acc_t'(1) <<< (DW-1));

  function automatic logic [DW-1:0] sat_fn(input acc_t v);
    if (v > S_MAX) return S_MAX[DW-1:0];
    if (v < S_MIN) return S_MIN[DW-1:0];
    return v[DW-1:0];
  endfunction
endpackage

// File: rtl/fdct_row_pass.sv
module fdct_row_pass
  import fdct_pkg::*;
(
  input  logic [NL*DW-1:0] row_i,
  output logic [NL*DW-1:0] coef_o
);
  acc_t x [NL];
  acc_t a1, b1, c1, d1;

  always_comb begin
    for (int n = 0; n < NL; n++) begin
      logic signed [DW-1:0] s;
      s    = row_i[n*DW +: DW];
      x[n] = s;
    end
    a1 = (x[0] + x[3]) <<< PRE_SH;
    b1 = (x[1] + x[2]) <<< PRE_SH;
    c1 = (x[1] - x[2]) <<< PRE_SH;
    d1 = (x[0] - x[3]) <<< PRE_SH;
    coef_o[0*DW +: DW] = sat_fn(a1 + b1);
    coef_o[2*DW +: DW] = sat_fn(a1 - b1);
    coef_o[1*DW +: DW] = sat_fn((c1 * W_LO + d1 * W_HI + H_RND1) >>> H_SH);
    coef_o[3*DW +: DW] = sat_fn((d1 * W_LO - c1 * W_HI + H_RND3) >>> H_SH);
  end
endmodule

// File: rtl/fdct_col_pass.sv
module fdct_col_pass
  import fdct_pkg::*;
(
  input  logic [NL*DW-1:0] col_i,
  output logic [NL*DW-1:0] coef_o
);
  acc_t r [NL];
  acc_t a1, b1, c1, d1, nz;

  always_comb begin
    for (int n = 0; n < NL; n++) begin
      logic signed [DW-1:0] s;
      s    = col_i[n*DW +: DW];
      r[n] = s;
    end
    a1 = r[0] + r[3];
    b1 = r[1] + r[2];
    c1 = r[1] - r[2];
    d1 = r[0] - r[3];
    nz = (d1 != '0) ? ACC_ONE : '0;
    coef_o[0*DW +: DW] = sat_fn((a1 + b1 + V_RND0) >>> V_SH0);
    coef_o[2*DW +: DW] = sat_fn((a1 - b1 + V_RND0) >>> V_SH0);
    coef_o[1*DW +: DW] = sat_fn(((c1 * W_LO + d1 * W_HI + V_RND1) >>> V_SH) + nz);
    coef_o[3*DW +: DW] = sat_fn((d1 * W_LO - c1 * W_HI + V_RND3) >>> V_SH);
  end
endmodule

// File: rtl/fdct_tbuf.sv
module fdct_tbuf
  import fdct_pkg::*;
#(
  parameter int unsigned BANKS = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_fire_i,
  input  logic [NL*DW-1:0]    wr_row_i,
  output logic                wr_ready_o,
  input  logic                rd_fire_i,
  output logic                rd_valid_o,
  output logic [RW-1:0]       rd_idx_o,
  output logic [NL*NL*DW-1:0] blk_o
);
  localparam int unsigned BW = (BANKS > 1) ? $clog2(BANKS) : 1;
  localparam logic [BW-1:0] LAST_BANK = BW'(BANKS - 1);
  localparam logic [RW-1:0] LAST_ROW  = RW'(NL - 1);

  logic [NL*DW-1:0] mem_q [BANKS][NL];
  logic [BANKS-1:0] full_q;
  logic [BW-1:0]    wr_bank_q, rd_bank_q;
  logic [RW-1:0]    wr_row_q, rd_row_q;

  function automatic logic [BW-1:0] bank_inc(input logic [BW-1:0] b);
    return (b == LAST_BANK) ? '0 : b + BW'(1);
  endfunction

  assign wr_ready_o = ~full_q[wr_bank_q];
  assign rd_valid_o = full_q[rd_bank_q];
  assign rd_idx_o   = rd_row_q;

  always_ff @(posedge clk_i) begin
    if (wr_fire_i) mem_q[wr_bank_q][wr_row_q] <= wr_row_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q    <= '0;
      wr_bank_q <= '0;
      rd_bank_q <= '0;
      wr_row_q  <= '0;
      rd_row_q  <= '0;
    end else begin
      if (wr_fire_i) begin
        wr_row_q <= wr_row_q + RW'(1);
        if (wr_row_q == LAST_ROW) begin
          full_q[wr_bank_q] <= 1'b1;
          wr_bank_q         <= bank_inc(wr_bank_q);
        end
      end
      if (rd_fire_i) begin
        rd_row_q <= rd_row_q + RW'(1);
        if (rd_row_q == LAST_ROW) begin
          full_q[rd_bank_q] <= 1'b0;
          rd_bank_q         <= bank_inc(rd_bank_q);
        end
      end
    end
  end

  always_comb begin
    for (int r = 0; r < NL; r++) blk_o[r*NL*DW +: NL*DW] = mem_q[rd_bank_q][r];
  end
endmodule

// File: rtl/fdct_engine.sv
module fdct_engine
  import fdct_pkg::*;
#(
  parameter int unsigned BANKS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [NL*DW-1:0] in_row_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [NL*DW-1:0] out_row_o
);
  logic                in_fire, out_fire;
  logic [NL*DW-1:0]    row_res;
  logic [NL*NL*DW-1:0] blk;
  logic [RW-1:0]       rd_idx;
  logic [NL*DW-1:0]    col_in  [NL];
  logic [NL*DW-1:0]    col_res [NL];

  assign in_fire  = in_valid_i & in_ready_o;
  assign out_fire = out_valid_o & out_ready_i;

  fdct_row_pass u_row (
    .row_i  (in_row_i),
    .coef_o (row_res)
  );

  fdct_tbuf #(.BANKS(BANKS)) u_tbuf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_fire_i  (in_fire),
    .wr_row_i   (row_res),
    .wr_ready_o (in_ready_o),
    .rd_fire_i  (out_fire),
    .rd_valid_o (out_valid_o),
    .rd_idx_o   (rd_idx),
    .blk_o      (blk)
  );

  for (genvar j = 0; j < NL; j++) begin : g_col
    for (genvar r = 0; r < NL; r++) begin : g_tap
      assign col_in[j][r*DW +: DW] = blk[(r*NL + j)*DW +: DW];
    end
    fdct_col_pass u_col (
      .col_i  (col_in[j]),
      .coef_o (col_res[j])
    );
    // lane j carries horizontal frequency j of vertical row rd_idx
    assign out_row_o[j*DW +: DW] = col_res[j][rd_idx*DW +: DW];
  end
endmodule

// File: rtl/fdct_engine_chk.sv
module fdct_engine_chk
  import fdct_pkg::*;
#(
  parameter int unsigned BANKS = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [NL*DW-1:0] out_row_o
);
  localparam int unsigned OW = $clog2(BANKS + 2);
  logic          in_fire, out_fire, in_done, out_done;
  logic [RW-1:0] in_beat_q, out_beat_q;
  logic [OW-1:0] occ_q;

  assign in_fire  = in_valid_i & in_ready_o;
  assign out_fire = out_valid_o & out_ready_i;
  assign in_done  = in_fire & (in_beat_q == RW'(NL - 1));
  assign out_done = out_fire & (out_beat_q == RW'(NL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_beat_q  <= '0;
      out_beat_q <= '0;
      occ_q      <= '0;
    end else begin
      if (in_fire)  in_beat_q  <= in_beat_q + RW'(1);
      if (out_fire) out_beat_q <= out_beat_q + RW'(1);
      occ_q <= occ_q + OW'(in_done) - OW'(out_done);
    end
  end

  // R8
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_row_o));

  // R10
  tile_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_done |=> out_valid_o);

  // R9
  occupancy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= OW'(BANKS));

  // R9
  backpressure_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> occ_q == OW'(BANKS));

  // R1
  empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q == '0 |-> !out_valid_o);
endmodule

bind fdct_engine fdct_engine_chk #(.BANKS(BANKS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_row_o   (out_row_o)
);

// File: tb/sim_fdct_engine.sv
`timescale 1ns/1ps
module sim_fdct_engine;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        in_valid_i;
  logic        in_ready_o;
  logic [63:0] in_row_i;
  logic        out_valid_o;
  logic        out_ready_i;
  logic [63:0] out_row_o;

  int checks = 0;
  int fails  = 0;
  int stalls = 0;
  int cycles = 0;
  int ready_mode = 0;  // 0 always ready, 1 hold, 2 random
  logic [63:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;
  always @(posedge clk) cycles++;

  fdct_engine u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_row_i(in_row_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_row_o(out_row_o)
  );

  function automatic longint sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic logic [255:0] model(input logic [255:0] blk);
    longint t [4][4];
    logic [255:0] o;
    for (int r = 0; r < 4; r++) begin
      longint x0, x1, x2, x3, a, b, c, d;
      x0 = longint'($signed(blk[(r*4+0)*16 +: 16]));
      x1 = longint'($signed(blk[(r*4+1)*16 +: 16]));
      x2 = longint'($signed(blk[(r*4+2)*16 +: 16]));
      x3 = longint'($signed(blk[(r*4+3)*16 +: 16]));
      a = (x0 + x3) * 8; b = (x1 + x2) * 8;
      c = (x1 - x2) * 8; d = (x0 - x3) * 8;
      t[r][0] = sat16(a + b);
      t[r][2] = sat16(a - b);
      t[r][1] = sat16((c * 2217 + d * 5352 + 14500) >>> 12);
      t[r][3] = sat16((d * 2217 - c * 5352 + 7500) >>> 12);
    end
    for (int j = 0; j < 4; j++) begin
      longint a, b, c, d, v0, v1, v2, v3;
      a = t[0][j] + t[3][j]; b = t[1][j] + t[2][j];
      c = t[1][j] - t[2][j]; d = t[0][j] - t[3][j];
      v0 = sat16((a + b + 7) >>> 4);
      v2 = sat16((a - b + 7) >>> 4);
      v1 = sat16(((c * 2217 + d * 5352 + 12000) >>> 16) + ((d != 0) ? 1 : 0));
      v3 = sat16((d * 2217 - c * 5352 + 51000) >>> 16);
      o[(0*4+j)*16 +: 16] = v0[15:0];
      o[(1*4+j)*16 +: 16] = v1[15:0];
      o[(2*4+j)*16 +: 16] = v2[15:0];
      o[(3*4+j)*16 +: 16] = v3[15:0];
    end
    return o;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // consumer and row checker
  initial begin
    out_ready_i = 1'b0;
    forever begin
      @(negedge clk);
      case (ready_mode)
        0: out_ready_i = 1'b1;
        1: out_ready_i = 1'b0;
        default: out_ready_i = 1'($urandom % 2);
      endcase
      if (rst_ni && out_valid_o && out_ready_i) begin
        if (exp_q.size() == 0) chk(1'b0, "R7 unexpected row", out_row_o, '0);
        else begin
          logic [63:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(out_row_o == e, t, out_row_o, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", '0, '0);
    report();
  end

  task automatic send_row(input logic [63:0] d);
    logic hs;
    in_row_i   = d;
    in_valid_i = 1'b1;
    forever begin
      hs = in_ready_o;
      if (!hs) stalls++;
      @(negedge clk);
      if (hs) break;
    end
    in_valid_i = 1'b0;
  endtask

  task automatic send_block(input logic [255:0] blk, input bit gaps, input string tag);
    logic [255:0] e;
    e = model(blk);
    for (int k = 0; k < 4; k++) begin
      exp_q.push_back(e[k*64 +: 64]);
      tag_q.push_back(tag);
    end
    for (int r = 0; r < 4; r++) begin
      if (gaps) repeat ($urandom % 3) @(negedge clk);
      send_row(blk[r*64 +: 64]);
    end
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(!out_valid_o, "R7 idle after drain", 64'(out_valid_o), 64'd0);
  endtask

  function automatic logic [255:0] rand_blk(input int mag);
    logic [255:0] b;
    for (int i = 0; i < 16; i++) begin
      int v;
      v = int'($urandom % (2 * mag + 1)) - mag;
      b[i*16 +: 16] = v[15:0];
    end
    return b;
  endfunction

  function automatic logic [255:0] fill_blk(input logic [15:0] v);
    logic [255:0] b;
    for (int i = 0; i < 16; i++) b[i*16 +: 16] = v;
    return b;
  endfunction

  task automatic t_reset_state;
    chk(in_ready_o && !out_valid_o, "R1 reset state", {62'd0, in_ready_o, out_valid_o}, 64'd2);
  endtask

  task automatic t_latency_zero;
    ready_mode = 1;
    send_block('0, 1'b0, "R7 zero tile");
    chk(out_valid_o, "R10 valid after fourth row", 64'(out_valid_o), 64'd1);
    chk(out_row_o == {16'd0, 16'd0, 16'd1, 16'd0}, "R4 R7 zero tile row0 hand value",
        out_row_o, {16'd0, 16'd0, 16'd1, 16'd0});
    ready_mode = 0;
    drain();
  endtask

  task automatic t_patterns;
    logic [255:0] ramp, alt;
    for (int i = 0; i < 16; i++) begin
      ramp[i*16 +: 16] = 16'(i * 7 - 40);
      alt[i*16 +: 16]  = (i % 2 == 0) ? 16'sd200 : -16'sd200;
    end
    send_block(ramp, 1'b0, "R2 R3 R4 ramp tile");
    send_block(alt, 1'b0, "R3 R6 alternating tile");
    send_block(fill_blk(16'd1), 1'b0, "R4 flat tile");
    for (int n = 0; n < 3; n++) send_block(rand_blk(255), 1'b0, "R4 R6 residual tile");
    drain();
  endtask

  task automatic t_saturation;
    logic [255:0] mix;
    send_block(fill_blk(16'sd32767), 1'b0, "R2 positive saturation");
    send_block(fill_blk(-16'sd32768), 1'b0, "R2 negative saturation");
    for (int i = 0; i < 16; i++)
      mix[i*16 +: 16] = (i % 4 == 0 || i % 4 == 1) ? 16'sd32767 : -16'sd32768;
    send_block(mix, 1'b0, "R3 R6 odd path saturation");
    for (int n = 0; n < 3; n++) send_block(rand_blk(32767), 1'b0, "R3 R6 full range tile");
    drain();
  endtask

  task automatic t_odd_correction;
    logic [255:0] same, top;
    for (int i = 0; i < 16; i++) begin
      same[i*16 +: 16] = 16'((i % 4) * 13 - 9);
      top[i*16 +: 16]  = (i < 4) ? 16'((i + 1) * 11) : 16'd0;
    end
    send_block(same, 1'b0, "R5 d zero no correction");
    send_block(top, 1'b0, "R5 d nonzero correction");
    drain();
  endtask

  task automatic t_backpressure;
    logic [63:0] held;
    ready_mode = 1;
    send_block(rand_blk(100), 1'b0, "R9 bank0 tile");
    send_block(rand_blk(100), 1'b0, "R9 bank1 tile");
    chk(!in_ready_o, "R9 ready low when both banks full", 64'(in_ready_o), 64'd0);
    held = out_row_o;
    repeat (3) @(negedge clk);
    chk(out_valid_o && out_row_o == held, "R8 output held under stall", out_row_o, held);
    ready_mode = 0;
    drain();
  endtask

  task automatic t_throughput;
    int c0;
    ready_mode = 0;
    stalls = 0;
    c0 = cycles;
    for (int n = 0; n < 4; n++) send_block(rand_blk(255), 1'b0, "R9 streaming tile");
    chk(stalls == 0 && cycles - c0 == 16, "R9 four tiles in sixteen cycles",
        64'(cycles - c0), 64'd16);
    drain();
  endtask

  task automatic t_random_stall;
    ready_mode = 2;
    for (int n = 0; n < 8; n++) send_block(rand_blk(511), 1'b1, "R8 tile under stalls");
    drain();
    ready_mode = 0;
  endtask

  task automatic t_mid_reset;
    send_row(64'h0123_4567_89ab_cdef);
    send_row(64'h7fff_8000_1111_2222);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk(in_ready_o && !out_valid_o, "R1 state during reset", {62'd0, in_ready_o, out_valid_o}, 64'd2);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(in_ready_o && !out_valid_o, "R1 state after reset", {62'd0, in_ready_o, out_valid_o}, 64'd2);
    send_block(rand_blk(300), 1'b0, "R1 tile after partial reset");
    drain();
  endtask

  initial begin
    rst_ni     = 1'b0;
    in_valid_i = 1'b0;
    in_row_i   = '0;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_latency_zero();
    t_patterns();
    t_saturation();
    t_odd_correction();
    t_backpressure();
    t_throughput();
    t_random_stall();
    t_mid_reset();
    report();
  end
endmodule